// File: doc/BRIEF.md
# Dual-Issue Pair Dependency Checker

This block takes a pair of 16-bit instruction words that fetch has latched together, the older one and the one after it. It decides in the same step whether the two may enter the two execution lanes in the same cycle. The decision covers three kinds of register conflict between the pair: read-after-write, write-after-write and write-after-read. It counts the implicit flag register (the top register, r7) as one of those registers. Compare writes it, and the two conditional branches read it. Some pairs are never co-issued: an older instruction that redirects control flow, and two memory operations that would both need the single data port.

When the pair is clean, both words go out in lane 0 and lane 1 and the block reports an advance of 2. When the pair conflicts, only the older word goes out. Lane 1 carries a NOP bubble (all-zero word, valid low) and the advance is 1. Fetch then moves the program counter by one word. The held younger word comes back as the older word of the next pair, so it issues one cycle later. The two issue slots and the advance count are registered, one cycle after the pair is presented.

Top module: `pair_issue_checker`

## Requirements
- R1: While reset is asserted and right after it, both lane valids are 0, both lane words are 16'h0000 and the advance count is 0.
- R2: In the cycle after a cycle with `pair_valid` low, both lane valids are 0, both lane words are 16'h0000 and the advance is 0, whatever the instruction inputs hold.
- R3: A conflict-free pair presented with `pair_valid` high appears one clock later with lane 0 = older word, lane 1 = younger word, both valid, and advance 2.
- R4: The pair is serialized (read-after-write) when the younger instruction reads a register that the older one writes. The fields are opcode [15:12], destination [11:9], source A [8:6] and source B [5:3].
- R5: The pair is serialized (write-after-write) when both instructions write the same register.
- R6: The pair is serialized (write-after-read) when the younger instruction writes a register that the older one reads.
- R7: Compare (opcode 0110) writes r7, and branch-if-equal (1110) and branch-if-greater (1111) read r7, even though no field names it. Any of these, or an explicit destination of r7, takes part in R4 to R6.
- R8: When the older instruction is jump (1100), branch-if-equal or branch-if-greater, the pair is always serialized.
- R9: When both instructions are memory operations (load 0100, store 0101), the pair is serialized. A single memory operation paired with a non-memory instruction may co-issue.
- R10: A serialized pair gives lane 0 = older word valid, lane 1 valid 0 with word 16'h0000, and advance 1.
- R11: Only fields an opcode uses count. Move (0111), not (1010) and load use source A only. Store reads both sources and writes nothing. Compare reads both sources. Jump and NOP (0000) use no register. The ALU opcodes 0001, 0010, 0011, 1000, 1001, 1011 and 1101 read both sources and write the destination. Bit 2 never matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_valid | input | 1 | The two instruction inputs hold a fetched pair |
| older_instr | input | 16 | First (older) instruction of the pair |
| younger_instr | input | 16 | Second (younger) instruction of the pair |
| lane0_valid | output | 1 | Lane 0 carries an instruction |
| lane0_instr | output | 16 | Instruction issued to lane 0 |
| lane1_valid | output | 1 | Lane 1 carries an instruction |
| lane1_instr | output | 16 | Instruction issued to lane 1, zero when bubbled |
| advance | output | 2 | Words consumed this issue: 0, 1 or 2 |

## Verification
The hardest pairs to reach are those where a conflict exists only through a register that no field names. One example is an ALU write to r7 followed by a conditional branch. Another is two compares in a row. A third is a word whose unused field happens to match the other instruction's destination, which must not serialize. The stimulus table encodes each of these as its own vector. Every field value is built by an encoding function, so the stray-field cases differ from a real conflict only in the opcode.

// File: rtl/pic_pkg.sv
package pic_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP   = 4'h0, OP_ADD  = 4'h1, OP_SUB  = 4'h2, OP_MUL  = 4'h3,
      OP_LOAD  = 4'h4, OP_STORE = 4'h5, OP_CMP = 4'h6, OP_MOV  = 4'h7,
      OP_OR    = 4'h8, OP_AND  = 4'h9, OP_NOT  = 4'hA, OP_LSL  = 4'hB,
      OP_JUMP  = 4'hC, OP_LSR  = 4'hD, OP_BEQ  = 4'hE, OP_BGT  = 4'hF
   } opcode_e;

   // Register usage class of one opcode
   typedef struct packed {
      logic src_a;    // reads source A field
      logic src_b;    // reads source B field
      logic dst;      // writes destination field
      logic flag_wr;  // writes the flag register implicitly
      logic flag_rd;  // reads the flag register implicitly
      logic mem;      // uses the data memory port
      logic redirect; // may change control flow
   } op_class_t;

   function automatic op_class_t classify(input logic [OPC_W-1:0] op);
      op_class_t c;
      c = '0;
      case (opcode_e'(op))
         OP_ADD, OP_SUB, OP_MUL, OP_OR, OP_AND, OP_LSL, OP_LSR: begin
            c.src_a = 1'b1; c.src_b = 1'b1; c.dst = 1'b1;
         end
         OP_MOV, OP_NOT: begin
            c.src_a = 1'b1; c.dst = 1'b1;
         end
         OP_LOAD: begin
            c.src_a = 1'b1; c.dst = 1'b1; c.mem = 1'b1;
         end
         OP_STORE: begin
            c.src_a = 1'b1; c.src_b = 1'b1; c.mem = 1'b1;
         end
         OP_CMP: begin
            c.src_a = 1'b1; c.src_b = 1'b1; c.flag_wr = 1'b1;
         end
         OP_BEQ, OP_BGT: begin
            c.flag_rd = 1'b1; c.redirect = 1'b1;
         end
         OP_JUMP: c.redirect = 1'b1;
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pic_decode.sv
module pic_decode #(
   parameter int INSTR_W  = 16,
   parameter int REG_BITS = 3,
   parameter int OPC_LSB  = 12,
   parameter int DST_LSB  = 9,
   parameter int SRCA_LSB = 6,
   parameter int SRCB_LSB = 3,
   parameter int FLAG_IDX = (1 << REG_BITS) - 1
) (
   input  logic [INSTR_W-1:0]          instr,
   output logic [(1 << REG_BITS)-1:0]  rd_mask,
   output logic [(1 << REG_BITS)-1:0]  wr_mask,
   output logic                        is_mem,
   output logic                        is_redirect
);
   import pic_pkg::*;

   localparam int NUM_REGS = 1 << REG_BITS;

   if (OPC_LSB + OPC_W > INSTR_W) begin : g_bad_opc
      $error("opcode field exceeds instruction width");
   end
   if (DST_LSB + REG_BITS > INSTR_W || SRCA_LSB + REG_BITS > INSTR_W ||
       SRCB_LSB + REG_BITS > INSTR_W) begin : g_bad_fld
      $error("register field exceeds instruction width");
   end
   if (FLAG_IDX >= NUM_REGS) begin : g_bad_flag
      $error("flag register index out of range");
   end

   op_class_t              cls;
   logic [REG_BITS-1:0]    dst_f, srca_f, srcb_f;
   logic [NUM_REGS-1:0]    flag_bit;

   assign cls      = classify(instr[OPC_LSB +: OPC_W]);
   assign dst_f    = instr[DST_LSB  +: REG_BITS];
   assign srca_f   = instr[SRCA_LSB +: REG_BITS];
   assign srcb_f   = instr[SRCB_LSB +: REG_BITS];
   assign flag_bit = NUM_REGS'(1) << FLAG_IDX;

   always_comb begin
      rd_mask = '0;
      wr_mask = '0;
      if (cls.src_a)   rd_mask = rd_mask | (NUM_REGS'(1) << srca_f);
      if (cls.src_b)   rd_mask = rd_mask | (NUM_REGS'(1) << srcb_f);
      if (cls.flag_rd) rd_mask = rd_mask | flag_bit;
      if (cls.dst)     wr_mask = wr_mask | (NUM_REGS'(1) << dst_f);
      if (cls.flag_wr) wr_mask = wr_mask | flag_bit;
   end

   assign is_mem      = cls.mem;
   assign is_redirect = cls.redirect;

   // Each instruction writes at most one register
   always_comb begin
      a_single_write_r11: assert ($countones(wr_mask) <= 1)
         else $error("more than one register written");
   end

endmodule

// File: rtl/pic_conflict.sv
module pic_conflict #(
   parameter int NUM_REGS      = 8,
   parameter bit SERIALIZE_MEM = 1'b1
) (
   input  logic [NUM_REGS-1:0] old_rd,
   input  logic [NUM_REGS-1:0] old_wr,
   input  logic                old_mem,
   input  logic                old_redirect,
   input  logic [NUM_REGS-1:0] yng_rd,
   input  logic [NUM_REGS-1:0] yng_wr,
   input  logic                yng_mem,
   output logic                raw,
   output logic                waw,
   output logic                war,
   output logic                mem_clash,
   output logic                ctrl_stop,
   output logic                co_issue
);

   assign raw       = |(old_wr & yng_rd);
   assign waw       = |(old_wr & yng_wr);
   assign war       = |(old_rd & yng_wr);
   assign ctrl_stop = old_redirect;

   if (SERIALIZE_MEM) begin : g_mem_serial
      assign mem_clash = old_mem & yng_mem;
   end else begin : g_mem_shared
      assign mem_clash = 1'b0;
   end

   assign co_issue = ~(raw | waw | war | mem_clash | ctrl_stop);

endmodule

// File: rtl/pair_issue_checker.sv
module pair_issue_checker #(
   parameter int INSTR_W       = 16,
   parameter int REG_BITS      = 3,
   parameter int OPC_LSB       = 12,
   parameter int DST_LSB       = 9,
   parameter int SRCA_LSB      = 6,
   parameter int SRCB_LSB      = 3,
   parameter bit SERIALIZE_MEM = 1'b1,
   parameter bit OUT_REG       = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pair_valid,
   input  logic [INSTR_W-1:0] older_instr,
   input  logic [INSTR_W-1:0] younger_instr,
   output logic               lane0_valid,
   output logic [INSTR_W-1:0] lane0_instr,
   output logic               lane1_valid,
   output logic [INSTR_W-1:0] lane1_instr,
   output logic [1:0]         advance
);

   localparam int NUM_REGS = 1 << REG_BITS;
   localparam int FLAG_IDX = NUM_REGS - 1;
   localparam int LANES    = 2;

   if (REG_BITS < 1) begin : g_bad_regs
      $error("REG_BITS must be at least 1");
   end

   logic [INSTR_W-1:0]  words   [LANES];
   logic [NUM_REGS-1:0] rd_m    [LANES];
   logic [NUM_REGS-1:0] wr_m    [LANES];
   logic [LANES-1:0]    mem_f;
   logic [LANES-1:0]    redir_f;

   assign words[0] = older_instr;
   assign words[1] = younger_instr;

   for (genvar g = 0; g < LANES; g++) begin : g_dec
      pic_decode #(
         .INSTR_W (INSTR_W),  .REG_BITS (REG_BITS),
         .OPC_LSB (OPC_LSB),  .DST_LSB  (DST_LSB),
         .SRCA_LSB(SRCA_LSB), .SRCB_LSB (SRCB_LSB),
         .FLAG_IDX(FLAG_IDX)
      ) u_dec (
         .instr      (words[g]),
         .rd_mask    (rd_m[g]),
         .wr_mask    (wr_m[g]),
         .is_mem     (mem_f[g]),
         .is_redirect(redir_f[g])
      );
   end

   logic raw, waw, war, mem_clash, ctrl_stop, co_issue;

   pic_conflict #(
      .NUM_REGS     (NUM_REGS),
      .SERIALIZE_MEM(SERIALIZE_MEM)
   ) u_conf (
      .old_rd      (rd_m[0]),
      .old_wr      (wr_m[0]),
      .old_mem     (mem_f[0]),
      .old_redirect(redir_f[0]),
      .yng_rd      (rd_m[1]),
      .yng_wr      (wr_m[1]),
      .yng_mem     (mem_f[1]),
      .raw         (raw),
      .waw         (waw),
      .war         (war),
      .mem_clash   (mem_clash),
      .ctrl_stop   (ctrl_stop),
      .co_issue    (co_issue)
   );

   // Next issue slot contents
   logic               n_v0, n_v1;
   logic [INSTR_W-1:0] n_i0, n_i1;
   logic [1:0]         n_adv;

   always_comb begin
      n_v0  = pair_valid;
      n_v1  = pair_valid & co_issue;
      n_i0  = pair_valid ? older_instr : '0;
      n_i1  = n_v1 ? younger_instr : '0;
      n_adv = !pair_valid ? 2'd0 : (co_issue ? 2'd2 : 2'd1);
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane0_valid <= 1'b0;
            lane0_instr <= '0;
            lane1_valid <= 1'b0;
            lane1_instr <= '0;
            advance     <= 2'd0;
         end else begin
            lane0_valid <= n_v0;
            lane0_instr <= n_i0;
            lane1_valid <= n_v1;
            lane1_instr <= n_i1;
            advance     <= n_adv;
         end
      end

      p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && !$past(pair_valid) |-> !lane0_valid && advance == 2'd0);
      p_raw_serial_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(pair_valid) && $past(raw) |-> !lane1_valid && advance == 2'd1);
      p_waw_serial_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(pair_valid) && $past(waw) |-> !lane1_valid);
      p_war_serial_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(pair_valid) && $past(war) |-> !lane1_valid);
      p_redirect_serial_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(pair_valid) && $past(ctrl_stop) |-> advance == 2'd1);
      p_mem_serial_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(pair_valid) && $past(mem_clash) |-> !lane1_valid);
      p_pair_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(pair_valid) |-> lane0_instr == $past(older_instr));
   end else begin : g_comb
      assign lane0_valid = n_v0;
      assign lane0_instr = n_i0;
      assign lane1_valid = n_v1;
      assign lane1_instr = n_i1;
      assign advance     = n_adv;
   end

   p_lane1_needs_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lane1_valid |-> lane0_valid && advance == 2'd2);
   p_bubble_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lane0_valid && !lane1_valid |-> lane1_instr == '0 && advance == 2'd1);

endmodule

// File: tb/pair_issue_checker_tb.sv
module pair_issue_checker_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 18;

   function automatic logic [15:0] enc(input int op, input int d, input int a, input int b);
      return 16'(((op & 15) << 12) | ((d & 7) << 9) | ((a & 7) << 6) | ((b & 7) << 3));
   endfunction

   // {older, younger, expected advance}
   localparam logic [33:0] VEC [NV] = '{
      {enc(1, 1, 2, 3), enc(2, 4, 5, 6), 2'd2},                 // R3 independent ALU pair
      {enc(1, 1, 2, 3), enc(2, 4, 1, 6), 2'd1},                 // R4 RAW via source A
      {enc(1, 1, 2, 3), enc(8, 4, 5, 1), 2'd1},                 // R4 RAW via source B
      {enc(3, 2, 3, 4), enc(9, 2, 5, 6), 2'd1},                 // R5 WAW
      {enc(1, 1, 2, 3), enc(7, 2, 4, 0), 2'd1},                 // R6 WAR
      {enc(6, 0, 1, 2), enc(14, 0, 0, 0), 2'd1},                // R7 compare then branch
      {enc(1, 7, 1, 2), enc(15, 0, 0, 0), 2'd1},                // R7 r7 write then branch
      {enc(6, 0, 1, 2), enc(6, 0, 3, 4), 2'd1},                 // R7 two compares
      {enc(6, 0, 1, 2), enc(1, 3, 4, 5), 2'd2},                 // R7 compare, ALU ignores flag
      {enc(12, 0, 0, 0), enc(1, 1, 2, 3), 2'd1},                // R8 jump first
      {enc(15, 0, 0, 0), enc(0, 0, 0, 0), 2'd1},                // R8 branch first
      {enc(1, 1, 2, 3), enc(12, 0, 0, 0), 2'd2},                // R8 jump second co-issues
      {enc(4, 1, 2, 0), enc(5, 0, 3, 4), 2'd1},                 // R9 load and store
      {enc(4, 1, 2, 0), enc(1, 3, 4, 5), 2'd2},                 // R9 load with ALU
      {enc(1, 1, 2, 3), enc(7, 4, 5, 1), 2'd2},                 // R11 move ignores source B
      {enc(5, 1, 2, 3), enc(1, 4, 1, 5), 2'd2},                 // R11 store writes nothing
      {enc(12, 4, 5, 6) | 16'h0004, enc(0, 4, 5, 6), 2'd1},     // R11 fields unused, R8 still
      {enc(10, 3, 4, 5) | 16'h0004, enc(4, 5, 6, 3), 2'd2}      // R11 not ignores source B
   };

   function automatic string tag_of(input int i);
      case (i)
         0:       return "R3";
         1, 2:    return "R4,R10";
         3:       return "R5,R10";
         4:       return "R6,R10";
         5, 6, 7: return "R7,R10";
         8:       return "R7,R3";
         9, 10, 16: return "R8,R10";
         11:      return "R8,R3";
         12:      return "R9,R10";
         13:      return "R9,R3";
         default: return "R11";
      endcase
   endfunction

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pair_valid = 1'b0;
   logic [15:0] older_instr = '0;
   logic [15:0] younger_instr = '0;
   logic        lane0_valid, lane1_valid;
   logic [15:0] lane0_instr, lane1_instr;
   logic [1:0]  advance;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pair_issue_checker u_dut (
      .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
      .older_instr(older_instr), .younger_instr(younger_instr),
      .lane0_valid(lane0_valid), .lane0_instr(lane0_instr),
      .lane1_valid(lane1_valid), .lane1_instr(lane1_instr),
      .advance(advance)
   );

   task automatic check_out(input string tag, input logic v0, input logic [15:0] i0,
                            input logic v1, input logic [15:0] i1, input logic [1:0] adv);
      n_checks++;
      if ({lane0_valid, lane0_instr, lane1_valid, lane1_instr, advance} !== {v0, i0, v1, i1, adv}) begin
         n_fail++;
         $display("FAIL %s: got v0=%b i0=%h v1=%b i1=%h adv=%0d, expected v0=%b i0=%h v1=%b i1=%h adv=%0d",
                  tag, lane0_valid, lane0_instr, lane1_valid, lane1_instr, advance,
                  v0, i0, v1, i1, adv);
      end
   endtask

   task automatic present(input logic v, input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      pair_valid = v;
      older_instr = a;
      younger_instr = b;
      @(negedge clk);
   endtask

   initial begin
      // R1: outputs idle during reset
      #(CLK_PERIOD * 2);
      check_out("R1", 1'b0, '0, 1'b0, '0, 2'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1", 1'b0, '0, 1'b0, '0, 2'd0);

      for (int i = 0; i < NV; i++) begin
         logic [15:0] a, b;
         logic [1:0]  e;
         {a, b, e} = VEC[i];
         present(1'b1, a, b);
         if (e == 2'd2) check_out(tag_of(i), 1'b1, a, 1'b1, b, 2'd2);
         else           check_out(tag_of(i), 1'b1, a, 1'b0, '0, 2'd1);
      end

      // R2: invalid pair, even a conflicting one, issues nothing
      present(1'b0, enc(1, 1, 2, 3), enc(2, 4, 5, 6));
      check_out("R2", 1'b0, '0, 1'b0, '0, 2'd0);
      present(1'b0, enc(6, 0, 1, 2), enc(14, 0, 0, 0));
      check_out("R2", 1'b0, '0, 1'b0, '0, 2'd0);

      // R10 then held word returns as older: serialized pair, then advance 1 replay
      present(1'b1, enc(1, 1, 2, 3), enc(2, 4, 1, 6));
      check_out("R10", 1'b1, enc(1, 1, 2, 3), 1'b0, '0, 2'd1);
      present(1'b1, enc(2, 4, 1, 6), enc(3, 5, 6, 2));
      check_out("R3", 1'b1, enc(2, 4, 1, 6), 1'b1, enc(3, 5, 6, 2), 2'd2);

      // R1: reset mid-run clears the slots
      @(negedge clk);
      pair_valid = 1'b1;
      older_instr = enc(1, 1, 2, 3);
      younger_instr = enc(2, 4, 5, 6);
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R1", 1'b0, '0, 1'b0, '0, 2'd0);
      pair_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R2", 1'b0, '0, 1'b0, '0, 2'd0);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule